// File: doc/BRIEF.md
# Priority Interrupt Arbiter and Vector Generator

This block collects every interrupt request in the system and forwards the most urgent one to the CPU. The candidates are a pending reset, a software interrupt, and a row of peripheral request lines. Peripheral lines compete only while the global mask input is clear. Reset and the software interrupt ignore the mask. The block picks the winner by fixed priority and shows the CPU a 16-bit vector address. The vectors are two bytes apart and fall in descending order from the top of the address space.

The CPU answers a request with a level acknowledge. In the first cycle that the acknowledge is sampled high, the current winner is latched. The vector then stays frozen until the acknowledge drops, so a request that arrives while the vector is being fetched cannot corrupt it. The granted source receives a one-cycle acknowledge pulse, which lets its flag logic clear itself. The software interrupt is a strobe. The block remembers it until it is granted. The number of peripheral lines is a parameter, and the arbiter supports up to 128 sources in total.

Top module: `irq_vec_arb`

## Requirements
- R1: After reset, with no request present, irq_o is 0, src_ack_o is all zero and vec_o reads 0xFFFE.
- R2: Fixed priority from highest to lowest is pending reset, then software interrupt, then peripheral line 0, line 1, and so on up to the last line. Source s gets vector 0xFFFE - 2*s, where reset is s=0, software is s=1 and line k is s=k+2. This gives line k the vector 0xFFFA - 2*k.
- R3: While mask_i is 1, peripheral lines are ignored. They do not raise irq_o, do not change vec_o and never receive an acknowledge pulse.
- R4: reset_pend_i and a pending software interrupt are served regardless of mask_i.
- R5: A one-cycle pulse on swi_i leaves the software interrupt pending until it is granted. The grant clears it, unless a new pulse arrives in the same cycle as the grant, in which case it stays pending.
- R6: In the first cycle where ack_i is sampled high while a source is eligible, the winner is latched. From the next cycle on, vec_o shows the latched vector. It keeps showing it, even if higher-priority requests appear, until the edge at which ack_i is sampled low.
- R7: src_ack_o has bit s set for exactly one cycle, the cycle after the grant, only for the granted source s. All other bits stay 0.
- R8: If ack_i is high while no source is eligible, nothing is latched, no acknowledge pulse is issued, and vec_o keeps following the live winner.
- R9: Holding ack_i high over many cycles produces only one acknowledge pulse. A new grant needs ack_i to be sampled low first.
- R10: With the default of 14 lines, the lowest-priority line (line 13) uses vector 0xFFE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_IRQ | Peripheral request levels, bit k is line k |
| mask_i | input | 1 | Global mask, 1 blocks peripheral lines |
| reset_pend_i | input | 1 | Reset pending flag, highest priority |
| swi_i | input | 1 | Software interrupt strobe |
| ack_i | input | 1 | CPU acknowledge level |
| irq_o | output | 1 | Some source is eligible |
| vec_o | output | 16 | Vector address of the winner or of the latched grant |
| src_ack_o | output | N_IRQ+2 | One-cycle acknowledge per source, bit 0 reset, bit 1 software, bit k+2 line k |

## Verification
Two kinds of collision are provoked.

The first is a grant colliding with a new request. A higher-priority line is raised in the same cycle as the acknowledge, or just after it. The bench then judges which vector gets frozen and whether it stays frozen.

The second is a new software strobe landing in the very cycle its earlier request is granted. The bench judges this by observing, after the acknowledge is released, that irq_o stays high and vec_o reads 0xFFFC. That shows the second request was not lost.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned VEC_W = 16;

  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] top,
                                              input int unsigned idx);
    return top - VEC_W'(idx * 2);
  endfunction
endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int N_IRQ = 14,
  localparam int N_SRC = N_IRQ + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] req_i,
  input  logic             mask_i,
  input  logic             reset_pend_i,
  input  logic             swi_i,
  input  logic             clr_swi_i,
  output logic [N_SRC-1:0] elig_o
);
  logic swi_pend_q;

  // a fresh strobe wins over the clear of the previous one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) swi_pend_q <= 1'b0;
    else         swi_pend_q <= (swi_pend_q & ~clr_swi_i) | swi_i;
  end

  assign elig_o[0] = reset_pend_i;
  assign elig_o[1] = swi_pend_q;

  for (genvar k = 0; k < N_IRQ; k++) begin : g_line
    assign elig_o[k+2] = req_i[k] & ~mask_i;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] elig_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins; scan downward so the last hit is the smallest
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |elig_i;
endmodule

// File: rtl/irq_grant.sv
module irq_grant #(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             grant_o,
  output logic             held_o,
  output logic [IDX_W-1:0] lat_idx_o,
  output logic [N_SRC-1:0] src_ack_o
);
  logic             held_q;
  logic [IDX_W-1:0] lat_q;
  logic [N_SRC-1:0] pulse_q;

  assign grant_o = ack_i & ~held_q & valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      held_q <= grant_o | (held_q & ack_i);
      if (grant_o) lat_q <= idx_i;
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q[s] <= 1'b0;
      else         pulse_q[s] <= grant_o && (idx_i == IDX_W'(s));
    end
  end

  assign held_o    = held_q;
  assign lat_idx_o = lat_q;
  assign src_ack_o = pulse_q;
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_vec_pkg::*;
#(
  parameter int N_IRQ = 14,
  parameter logic [15:0] VEC_TOP = 16'hFFFE,
  localparam int N_SRC = N_IRQ + 2,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] req_i,
  input  logic             mask_i,
  input  logic             reset_pend_i,
  input  logic             swi_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [15:0]      vec_o,
  output logic [N_SRC-1:0] src_ack_o
);
  logic [N_SRC-1:0] elig;
  logic             valid;
  logic [IDX_W-1:0] win_idx;
  logic [IDX_W-1:0] lat_idx;
  logic             grant;
  logic             held;
  logic             clr_swi;

  assign clr_swi = grant && (win_idx == IDX_W'(1));

  irq_src_gate #(.N_IRQ(N_IRQ)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .mask_i      (mask_i),
    .reset_pend_i(reset_pend_i),
    .swi_i       (swi_i),
    .clr_swi_i   (clr_swi),
    .elig_o      (elig)
  );

  irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .elig_i (elig),
    .valid_o(valid),
    .idx_o  (win_idx)
  );

  irq_grant #(.N_SRC(N_SRC)) u_grant (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ack_i    (ack_i),
    .valid_i  (valid),
    .idx_i    (win_idx),
    .grant_o  (grant),
    .held_o   (held),
    .lat_idx_o(lat_idx),
    .src_ack_o(src_ack_o)
  );

  assign irq_o = valid;
  assign vec_o = held ? vec_of(VEC_TOP, int'(lat_idx)) : vec_of(VEC_TOP, int'(win_idx));
endmodule

// File: rtl/irq_vec_arb_chk.sv
module irq_vec_arb_chk #(
  parameter int N_SRC = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mask_i,
  input logic             reset_pend_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [15:0]      vec_o,
  input logic [N_SRC-1:0] src_ack_o,
  input logic             held_i
);
  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_ack_o)); // R7

  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ack_o != '0) |=> (src_ack_o == '0)); // R9

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ack_o != '0) |-> ($past(ack_i) && $past(irq_o))); // R8

  AST_MASKED_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_ack_o[N_SRC-1:2]) |-> !$past(mask_i)); // R3

  AST_RESET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_ack_o != '0) && $past(reset_pend_i)) |-> src_ack_o[0]); // R2

  AST_VEC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_i && $past(held_i)) |-> $stable(vec_o)); // R6
endmodule

bind irq_vec_arb irq_vec_arb_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mask_i      (mask_i),
  .reset_pend_i(reset_pend_i),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .src_ack_o   (src_ack_o),
  .held_i      (held)
);

// File: tb/irq_vec_arb_test.sv
module irq_vec_arb_test;
  localparam int N_IRQ = 14;
  localparam int N_SRC = N_IRQ + 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_IRQ-1:0] req_i = '0;
  logic             mask_i = 1'b0;
  logic             reset_pend_i = 1'b0;
  logic             swi_i = 1'b0;
  logic             ack_i = 1'b0;
  logic             irq_o;
  logic [15:0]      vec_o;
  logic [N_SRC-1:0] src_ack_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vec_arb #(.N_IRQ(N_IRQ)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .mask_i(mask_i),
    .reset_pend_i(reset_pend_i), .swi_i(swi_i), .ack_i(ack_i),
    .irq_o(irq_o), .vec_o(vec_o), .src_ack_o(src_ack_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] line_vec(input int k);
    return 16'hFFFA - 16'(2 * k);
  endfunction

  // drive just after a falling edge; checks follow after a short settle
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 irq_o idle", 32'(irq_o), 32'd0);
    chk("R1 vec_o idle", 32'(vec_o), 32'hFFFE);
    chk("R1 src_ack_o idle", 32'(src_ack_o), 32'd0);
  endtask

  task automatic t_priority();
    step();
    req_i = '0; req_i[3] = 1'b1; req_i[7] = 1'b1; req_i[13] = 1'b1;
    #1;
    chk("R2 irq_o with lines", 32'(irq_o), 32'd1);
    chk("R2 line3 wins", 32'(vec_o), 32'(line_vec(3)));
    step();
    req_i = '0; req_i[13] = 1'b1;
    #1;
    chk("R10 line13 vector", 32'(vec_o), 32'hFFE0);
    step();
    req_i[0] = 1'b1;
    #1;
    chk("R2 line0 vector", 32'(vec_o), 32'hFFFA);
    step();
    req_i = '0;
  endtask

  task automatic t_mask();
    step();
    mask_i = 1'b1; req_i[5] = 1'b1;
    #1;
    chk("R3 masked irq_o", 32'(irq_o), 32'd0);
    chk("R3 masked vec_o", 32'(vec_o), 32'hFFFE);
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    #1;
    chk("R8 no pulse when idle", 32'(src_ack_o), 32'd0);
    chk("R8 vec follows live", 32'(vec_o), 32'hFFFE);
    step();
    mask_i = 1'b0;
    #1;
    chk("R3 unmasked line5", 32'(vec_o), 32'(line_vec(5)));
    step();
    req_i = '0;
  endtask

  task automatic t_bypass();
    step();
    mask_i = 1'b1; req_i[5] = 1'b1; reset_pend_i = 1'b1;
    #1;
    chk("R4 reset under mask irq", 32'(irq_o), 32'd1);
    chk("R4 reset vector", 32'(vec_o), 32'hFFFE);
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    #1;
    chk("R2 reset acknowledged", 32'(src_ack_o), 32'd1);
    reset_pend_i = 1'b0; swi_i = 1'b1;
    step();
    swi_i = 1'b0;
    #1;
    chk("R4 swi under mask", 32'(vec_o), 32'hFFFC);
    step(); step();
    #1;
    chk("R5 swi still pending", 32'(irq_o), 32'd1);
    ack_i = 1'b1;
    step();
    #1;
    chk("R7 swi ack pulse", 32'(src_ack_o), 32'd2);
    ack_i = 1'b0;
    step();
    #1;
    chk("R5 swi cleared by grant", 32'(irq_o), 32'd0);
    mask_i = 1'b0; req_i = '0;
  endtask

  task automatic t_hold();
    step();
    req_i[4] = 1'b1; ack_i = 1'b1;
    step();
    #1;
    chk("R7 line4 pulse", 32'(src_ack_o), 32'(1 << 6));
    chk("R6 latched vector", 32'(vec_o), 32'(line_vec(4)));
    req_i[0] = 1'b1;
    step();
    #1;
    chk("R6 frozen vs higher req", 32'(vec_o), 32'(line_vec(4)));
    chk("R7 pulse one cycle", 32'(src_ack_o), 32'd0);
    step(); step();
    #1;
    chk("R9 no repeat pulse", 32'(src_ack_o), 32'd0);
    chk("R6 still frozen", 32'(vec_o), 32'(line_vec(4)));
    ack_i = 1'b0;
    #1;
    chk("R6 held until edge", 32'(vec_o), 32'(line_vec(4)));
    step();
    #1;
    chk("R6 released follows live", 32'(vec_o), 32'hFFFA);
    req_i = '0;
  endtask

  task automatic t_same_cycle();
    step();
    req_i[9] = 1'b1; req_i[1] = 1'b1; ack_i = 1'b1;
    step();
    #1;
    chk("R6 new req same cycle as ack", 32'(src_ack_o), 32'(1 << 3));
    ack_i = 1'b0; req_i = '0; mask_i = 1'b1;
    swi_i = 1'b1;
    step();
    swi_i = 1'b0;
    step();
    ack_i = 1'b1; swi_i = 1'b1;
    step();
    swi_i = 1'b0;
    #1;
    chk("R5 swi granted", 32'(src_ack_o), 32'd2);
    ack_i = 1'b0;
    step();
    #1;
    chk("R5 re-strobe kept pending", 32'(irq_o), 32'd1);
    chk("R5 re-strobe vector", 32'(vec_o), 32'hFFFC);
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    step();
    #1;
    chk("R5 second swi cleared", 32'(irq_o), 32'd0);
    mask_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_priority();
    t_mask();
    t_bypass();
    t_hold();
    t_same_cycle();
    step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule